// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. It sits between a TLB, or any other requester, and a word-read memory port. It handles one walk at a time. When a request is accepted, the walker picks one of two table base registers. The choice depends on a 3-bit split value and the top bits of the virtual address. The walker then fetches the first-level descriptor. If that descriptor points to a second-level table, it fetches the second-level descriptor as well.

The result gives the physical address, a page-size code, a global flag taken from the descriptor's non-global bit, and a fault indication. When the walk faults, the result also says whether the abort is a prefetch abort or a data abort, following the access type of the original request. The result is held until the requester acknowledges it. Only after that acknowledge does the walker accept new work.

Top module: `ptw_walker`

## Requirements
- R1: When split_n is 0, base 0 is always used. When split_n is N > 0, base 0 is used if VA[31:32-N] are all zero, and base 1 is used otherwise.
- R2: With base 1, the first read goes to {ttb1[31:14], VA[31:20], 2'b00}. With base 0, the first read goes to ttb0 with its low 14-N bits cleared, OR'd with VA[31-N:20] shifted left by 2. Example: ttb0=0x12300000 with VA=0x00100000 reads 0x12300004.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk with a fault after that single read.
- R4: A first-level descriptor with [1:0]=10 and bit 18 = 0 is a 1MB section. It gives pa={d[31:20],VA[19:0]}, size code 2, global = !d[17], and no second read.
- R5: A first-level descriptor with [1:0]=10 and bit 18 = 1 is a 16MB supersection. It gives pa={d[31:24],VA[23:0]}, size code 3, global = !d[17], and no second read.
- R6: A first-level descriptor with [1:0]=01 causes a second read at {d[31:10], VA[19:12], 2'b00}.
- R7: A second-level descriptor with [1:0]=01 is a 64KB page with pa={d[31:16],VA[15:0]} and size code 1. A second-level descriptor with bit 1 set is a 4KB page with pa={d[31:12],VA[11:0]} and size code 0. In both cases global = !d[11].
- R8: A second-level descriptor with [1:0]=00 ends the walk with a fault.
- R9: A fault result has res_fault=1, pa=0, size 0 and global 0. res_fault_fetch equals the req_fetch value captured at acceptance: 1 means a prefetch abort, 0 means a data abort.
- R10: req_ready is high only when the walker is idle. A request presented while a walk is in progress is ignored and does not change that walk's result.
- R11: res_valid and the result fields stay stable until res_ack is seen. After the acknowledge, the walker returns to idle.
- R12: A memory read request stays asserted with a stable address until mem_req_ready is high. No request is issued while a result is pending.
- R13: After reset, req_ready=1, res_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| ttb0 | input | 32 | Table base register 0 |
| ttb1 | input | 32 | Table base register 1 |
| split_n | input | 3 | Base split control N |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result available |
| res_ack | input | 1 | Requester consumed the result |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0=4KB, 1=64KB, 2=1MB, 3=16MB |
| res_global | output | 1 | Mapping is global |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_fetch | output | 1 | Fault is a prefetch abort (else data) |

## Verification
Directed vectors cover specific corner cases:
- the worked address example;
- both sides of the split boundary at N=7 (VA 0x01F00000 against 0x02000000);
- N=0, where every address must use base 0;
- each descriptor encoding, including the reserved 11 first-level code.

Seeded random vectors then mix random bases, split values, addresses and descriptors of all seven kinds. Top-bit masking is applied half the time so that both base registers are exercised. Random memory stalls and latencies check that request addresses are held and that the walker waits correctly. Junk requests are driven during walks, which shows whether a busy walker ignores them. Checking the first and second read addresses separately from the final result tells a wrong table index apart from a wrong output composition.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W    = 32;
    localparam int SPLIT_W   = 3;
    localparam int L1_IDX_W  = 12;
    localparam int L2_IDX_W  = 8;
    localparam int L1_SPAN_W = L1_IDX_W + 2;  // full first-level table: 16KB

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        STEP_FAULT = 2'd0,
        STEP_NEXT  = 2'd1,
        STEP_LEAF  = 2'd2
    } step_e;

    // Outcome of decoding one descriptor: either a next-read address or a leaf PA
    typedef struct packed {
        step_e             kind;
        logic [ADDR_W-1:0] addr;
        pg_size_e          size;
        logic              global_map;
    } step_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        pg_size_e          size;
        logic              global_map;
        logic              fault;
        logic              fetch;
    } walk_res_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_st_e;

    function automatic walk_res_t fault_result(input logic fetch);
        walk_res_t r;
        r.pa         = '0;
        r.size       = PG_4K;
        r.global_map = 1'b0;
        r.fault      = 1'b1;
        r.fetch      = fetch;
        return r;
    endfunction

    function automatic walk_res_t leaf_result(input step_t s, input logic fetch);
        walk_res_t r;
        r.pa         = s.addr;
        r.size       = s.size;
        r.global_map = s.global_map;
        r.fault      = 1'b0;
        r.fetch      = fetch;
        return r;
    endfunction

endpackage

// File: rtl/ptw_base_sel.sv
module ptw_base_sel
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0]  va,
    input  logic [ADDR_W-1:0]  ttb0,
    input  logic [ADDR_W-1:L1_SPAN_W] ttb1_hi,
    input  logic [SPLIT_W-1:0] split_n,
    output logic               use_base0,
    output logic [ADDR_W-1:0]  l1_addr
);
    logic [ADDR_W-1:0]   top_mask;
    logic [ADDR_W-1:0]   align_mask;
    logic [L1_IDX_W-1:0] idx;
    logic [L1_IDX_W-1:0] idx_mask;
    logic [4:0]          span0;

    always_comb begin
        idx        = va[ADDR_W-1 -: L1_IDX_W];
        top_mask   = ~({ADDR_W{1'b1}} >> split_n);
        use_base0  = ((va & top_mask) == '0);
        span0      = 5'(L1_SPAN_W) - {2'b00, split_n};
        align_mask = {ADDR_W{1'b1}} << span0;
        idx_mask   = {L1_IDX_W{1'b1}} >> split_n;
        if (use_base0)
            l1_addr = (ttb0 & align_mask) |
                      {{(ADDR_W-L1_IDX_W-2){1'b0}}, idx & idx_mask, 2'b00};
        else
            l1_addr = {ttb1_hi, idx, 2'b00};
    end
endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:10] d_hi,
    input  logic [1:0]         d_type,
    input  logic [23:0]        va_lo,
    output step_t              step
);
    always_comb begin
        step = '{kind: STEP_FAULT, addr: '0, size: PG_4K, global_map: 1'b0};
        unique case (d_type)
            2'b01: begin
                step.kind = STEP_NEXT;
                step.addr = {d_hi, va_lo[19:12], 2'b00};
            end
            2'b10: begin
                step.kind       = STEP_LEAF;
                step.global_map = ~d_hi[17];
                if (d_hi[18]) begin
                    step.addr = {d_hi[31:24], va_lo[23:0]};
                    step.size = PG_16M;
                end else begin
                    step.addr = {d_hi[31:20], va_lo[19:0]};
                    step.size = PG_1M;
                end
            end
            default: step.kind = STEP_FAULT;  // 00 and reserved 11
        endcase
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:11] d_hi,
    input  logic [1:0]         d_type,
    input  logic [15:0]        va_lo,
    output step_t              step
);
    always_comb begin
        step = '{kind: STEP_FAULT, addr: '0, size: PG_4K, global_map: 1'b0};
        if (d_type[1]) begin
            step.kind       = STEP_LEAF;
            step.addr       = {d_hi[31:12], va_lo[11:0]};
            step.size       = PG_4K;
            step.global_map = ~d_hi[11];
        end else if (d_type[0]) begin
            step.kind       = STEP_LEAF;
            step.addr       = {d_hi[31:16], va_lo[15:0]};
            step.size       = PG_64K;
            step.global_map = ~d_hi[11];
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_va,
    input  logic               req_fetch,
    input  logic [ADDR_W-1:0]  ttb0,
    input  logic [ADDR_W-1:0]  ttb1,
    input  logic [SPLIT_W-1:0] split_n,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic               res_valid,
    input  logic               res_ack,
    output logic [ADDR_W-1:0]  res_pa,
    output logic [1:0]         res_size,
    output logic               res_global,
    output logic               res_fault,
    output logic               res_fault_fetch
);
    walk_st_e          st;
    logic [23:0]       va_q;
    logic              fetch_q;
    logic [ADDR_W-1:0] l1_addr_q;
    logic [ADDR_W-1:0] l2_addr_q;
    walk_res_t         res_q;

    logic              sel_base0;
    logic [ADDR_W-1:0] l1_addr_c;
    step_t             l1_step;
    step_t             l2_step;

    ptw_base_sel u_base_sel (
        .va        (req_va),
        .ttb0      (ttb0),
        .ttb1_hi   (ttb1[ADDR_W-1:L1_SPAN_W]),
        .split_n   (split_n),
        .use_base0 (sel_base0),
        .l1_addr   (l1_addr_c)
    );

    ptw_l1_decode u_l1_dec (
        .d_hi   (mem_rsp_data[ADDR_W-1:10]),
        .d_type (mem_rsp_data[1:0]),
        .va_lo  (va_q),
        .step   (l1_step)
    );

    ptw_l2_decode u_l2_dec (
        .d_hi   (mem_rsp_data[ADDR_W-1:11]),
        .d_type (mem_rsp_data[1:0]),
        .va_lo  (va_q[15:0]),
        .step   (l2_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            fetch_q   <= 1'b0;
            l1_addr_q <= '0;
            l2_addr_q <= '0;
            res_q     <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q      <= req_va[23:0];
                    fetch_q   <= req_fetch;
                    l1_addr_q <= l1_addr_c;
                    st        <= ST_L1_REQ;
                end
                ST_L1_REQ:  if (mem_req_ready) st <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    unique case (l1_step.kind)
                        STEP_NEXT: begin
                            l2_addr_q <= l1_step.addr;
                            st        <= ST_L2_REQ;
                        end
                        STEP_LEAF: begin
                            res_q <= leaf_result(l1_step, fetch_q);
                            st    <= ST_DONE;
                        end
                        default: begin
                            res_q <= fault_result(fetch_q);
                            st    <= ST_DONE;
                        end
                    endcase
                end
                ST_L2_REQ:  if (mem_req_ready) st <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (l2_step.kind == STEP_LEAF) res_q <= leaf_result(l2_step, fetch_q);
                    else                           res_q <= fault_result(fetch_q);
                    st <= ST_DONE;
                end
                ST_DONE:    if (res_ack) st <= ST_IDLE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready       = (st == ST_IDLE);
    assign mem_req_valid   = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    assign mem_req_addr    = (st == ST_L2_REQ) ? l2_addr_q : l1_addr_q;
    assign res_valid       = (st == ST_DONE);
    assign res_pa          = res_q.pa;
    assign res_size        = res_q.size;
    assign res_global      = res_q.global_map;
    assign res_fault       = res_q.fault;
    assign res_fault_fetch = res_q.fetch;

    // R12: a read request is held with a stable address until accepted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R12: no memory request while a result is pending
    a_r12_no_req_with_result: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !mem_req_valid);

    // R11: result held until acknowledged
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ack |=> res_valid && $stable(res_pa) && $stable(res_size)
                                  && $stable(res_fault) && $stable(res_global));

    // R11: acknowledge returns the walker to idle
    a_r11_ack_idle: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ack |=> req_ready);

    // R10: idle means no walk activity
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid && !res_valid);

    // R10: a request accepted in idle starts a read on the next cycle
    a_r10_accept_starts: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid |=> mem_req_valid && !req_ready);

    // R9: fault results carry zero address and no global flag
    a_r9_fault_clean: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault |-> res_pa == '0 && !res_global && res_size == 2'd0);
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_fetch;
    logic [31:0] req_va, ttb0, ttb1;
    logic [2:0]  split_n;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic        res_valid, res_ack, res_global, res_fault, res_fault_fetch;
    logic [31:0] res_pa;
    logic [1:0]  res_size;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_fetch(req_fetch), .ttb0(ttb0), .ttb1(ttb1),
        .split_n(split_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ack(res_ack),
        .res_pa(res_pa), .res_size(res_size), .res_global(res_global),
        .res_fault(res_fault), .res_fault_fetch(res_fault_fetch)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_l1addr(input logic [31:0] va, input logic [31:0] b0,
                                             input logic [31:0] b1, input int n);
        logic [11:0] ix;
        logic [31:0] tbl;
        if (n == 0 || (va >> (32 - n)) == 0) begin
            ix  = va[31:20];
            ix  = ix << n;
            ix  = ix >> n;
            tbl = (b0 >> (14 - n)) << (14 - n);
            return tbl | {18'd0, ix, 2'b00};
        end
        return {b1[31:14], va[31:20], 2'b00};
    endfunction

    // expected outcome: reads, second read address, pa, size, global, fault
    task automatic m_walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                          output int reads, output logic [31:0] l2a, output logic [31:0] pa,
                          output logic [1:0] sz, output logic g, output logic flt);
        reads = 1; l2a = 0; pa = 0; sz = 0; g = 0; flt = 1;
        if (d1[1:0] == 2'b10) begin
            flt = 0; g = !d1[17];
            if (d1[18]) begin pa = {d1[31:24], va[23:0]}; sz = 3; end
            else        begin pa = {d1[31:20], va[19:0]}; sz = 2; end
        end else if (d1[1:0] == 2'b01) begin
            reads = 2;
            l2a = {d1[31:10], va[19:12], 2'b00};
            if (d2[1]) begin flt = 0; g = !d2[11]; pa = {d2[31:12], va[11:0]}; sz = 0; end
            else if (d2[0]) begin flt = 0; g = !d2[11]; pa = {d2[31:16], va[15:0]}; sz = 1; end
        end
    endtask

    task automatic serve(input logic [31:0] data, input string tag, input logic [31:0] exp_addr);
        int k;
        logic [31:0] a0;
        k = 0;
        while (!mem_req_valid && k < 40) begin @(negedge clk); k++; end
        chk(mem_req_valid, {tag, " read issued"}, 32'(mem_req_valid), 1);
        a0 = mem_req_addr;
        repeat ($urandom % 3) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == a0, "R12 request held", mem_req_addr, a0);
        chk(mem_req_addr == exp_addr, {tag, " read address"}, mem_req_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = $urandom;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] b0, input logic [31:0] b1,
                        input int n, input logic fetch, input logic [31:0] d1,
                        input logic [31:0] d2, input bit junk, input string tag);
        int reads, k;
        logic [31:0] l2a, pa;
        logic [1:0] sz;
        logic g, flt;
        m_walk(va, d1, d2, reads, l2a, pa, sz, g, flt);
        ttb0 = b0; ttb1 = b1; split_n = 3'(n);
        req_va = va; req_fetch = fetch; req_valid = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R10 busy after accept", 32'(req_ready), 0);
        req_valid = junk;
        req_va    = ~va;
        req_fetch = ~fetch;
        serve(d1, {tag, " R1/R2 first"}, m_l1addr(va, b0, b1, n));
        if (reads == 2) serve(d2, {tag, " R6 second"}, l2a);
        k = 0;
        while (!res_valid && k < 40) begin @(negedge clk); k++; end
        chk(res_valid, {tag, " result valid"}, 32'(res_valid), 1);
        chk(!mem_req_valid, {tag, " R3/R4/R12 no extra read"}, 32'(mem_req_valid), 0);
        chk(res_fault == flt, {tag, " R3/R8 fault"}, 32'(res_fault), 32'(flt));
        chk(res_pa == pa, {tag, " R4/R5/R7/R9 pa"}, res_pa, pa);
        chk(res_size == sz, {tag, " R4/R5/R7 size"}, 32'(res_size), 32'(sz));
        chk(res_global == g, {tag, " R4/R7 global"}, 32'(res_global), 32'(g));
        if (flt) chk(res_fault_fetch == fetch, {tag, " R9 abort kind"},
                     32'(res_fault_fetch), 32'(fetch));
        repeat ($urandom % 3) @(negedge clk);
        chk(res_valid && res_pa == pa, "R11 result held", res_pa, pa);
        res_ack = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        res_ack = 1'b0;
        chk(req_ready && !res_valid && !mem_req_valid, "R11/R10 idle after ack",
            32'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, d1, d2, b0, b1;
        int n, kind;
        void'($urandom(32'd7351));
        rst = 1; req_valid = 0; req_va = 0; req_fetch = 0; ttb0 = 0; ttb1 = 0; split_n = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; res_ack = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_req_valid, "R13 reset state", 32'(req_ready), 1);

        // worked example, section: R2 R4
        walk(32'h0010_0000, 32'h1230_0000, 32'hABCD_C000, 0, 0, 32'h4560_0C02, 0, 0, "dir ex");
        // N=7 boundary: base 0 vs base 1 (R1)
        walk(32'h01F0_0ABC, 32'h8000_3F80, 32'h4444_C000, 7, 0, 32'h7770_0002, 0, 0, "dir n7 lo");
        walk(32'h0200_0ABC, 32'h8000_3F80, 32'h4444_C000, 7, 0, 32'h7772_0002, 0, 0, "dir n7 hi");
        // N=0: top address still uses base 0 (R1)
        walk(32'hFFF1_2345, 32'h1000_0000, 32'h2000_0000, 0, 1, 32'hFE04_0002, 0, 1, "dir n0");
        // supersection (R5)
        walk(32'h1234_5678, 32'h0000_4000, 32'h0, 1, 0, 32'hAB04_0002, 0, 0, "dir super");
        // fault 00 / 11 with both access kinds (R3 R9)
        walk(32'h0030_0000, 32'h0000_8000, 32'h0, 0, 1, 32'hFFFF_FFFC, 0, 1, "dir f00");
        walk(32'h0030_0000, 32'h0000_8000, 32'h0, 0, 0, 32'hFFFF_FFFF, 0, 0, "dir f11");
        // second level: large, small, fault (R6 R7 R8)
        walk(32'h0055_ABCD, 32'h0001_0000, 32'h0, 0, 0, 32'h1234_5401, 32'h9876_0801, 0, "dir large");
        walk(32'h0055_ABCD, 32'h0001_0000, 32'h0, 0, 0, 32'h1234_5401, 32'h9876_5002, 1, "dir small");
        walk(32'h0055_ABCD, 32'h0001_0000, 32'h0, 0, 1, 32'h1234_5401, 32'h9876_5FFC, 0, "dir l2f");

        for (int i = 0; i < 400; i++) begin
            n  = $urandom % 8;
            va = $urandom;
            if ($urandom % 2 == 1 && n > 0) va = va & (32'hFFFF_FFFF >> n);
            b0 = $urandom; b1 = $urandom;
            d1 = $urandom; d2 = $urandom;
            kind = $urandom % 7;
            case (kind)
                0: d1[1:0] = 2'b00;
                1: d1[1:0] = 2'b11;
                2: begin d1[1:0] = 2'b10; d1[18] = 1'b0; end
                3: begin d1[1:0] = 2'b10; d1[18] = 1'b1; end
                4: begin d1[1:0] = 2'b01; d2[1:0] = 2'b00; end
                5: begin d1[1:0] = 2'b01; d2[1:0] = 2'b01; end
                default: begin d1[1:0] = 2'b01; d2[1] = 1'b1; end
            endcase
            walk(va, b0, b1, n, 1'($urandom), d1, d2, 1'($urandom), "rnd");
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule